// File: doc/BRIEF.md
# Two-Bank Program Counter with Return Stack

This block holds the 12-bit fetch address for a 4K program space split into two 2K halves. The instruction decoder drives it with single-cycle control pulses: advance, jump, call, return, return from interrupt, select lower half, select upper half, and interrupt entry. It answers with the registered fetch address and a flag that is high while an interrupt handler runs. The upper address bit is never touched by counting. It follows a separate half-select flag, and that flag takes effect only when a jump or a call loads the address.

Calls and interrupt entries save a full 12-bit resume address on an eight-slot circular stack. When a ninth address is saved, the oldest slot is overwritten. While a handler runs, the upper address bit stays at zero whatever the half-select flag says. A half-select pulse inside the handler still updates the flag, so the new value governs the first jump or call after the handler returns.

Top module: `bank_pc_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the next state is pc=000h, isr_active=0, half-select flag cleared, stack pointer at slot 0. After reset, a jump lands in the lower half.
- R2: An advance pulse adds one to pc[10:0] and leaves pc[11] unchanged. The low 11 bits wrap inside the current half (7FFh goes to 000h, FFFh goes to 800h).
- R3: bank1_sel sets the half-select flag and bank0_sel clears it. If both are high, bank1_sel wins. Neither pulse changes pc.
- R4: A jump or a call loads pc[10:0] from target and pc[11] from the half-select flag as it was before that edge.
- R5: A call saves {pc[11], pc[10:0]+1} on the stack. A return loads all 12 saved bits into pc and leaves the half-select flag unchanged.
- R6: An accepted interrupt saves the current pc, loads pc with 003h when irq_vec_sel=0 or 007h when irq_vec_sel=1, and sets isr_active.
- R7: While isr_active is high, pc[11] stays 0 through jumps, calls, returns and advances. Half-select pulses still update the flag.
- R8: A return from interrupt loads all 12 saved bits into pc and clears isr_active.
- R9: An interrupt pulse while isr_active is high has no effect. Nothing is saved and pc is not redirected.
- R10: The stack has eight slots used circularly. After nine saves without restores, the next eight restores give the newest eight addresses, newest first, and the ninth restore gives the newest address again.
- R11: When several control pulses are high together, only one acts. The order is: accepted interrupt, then call, jump, return from interrupt, return, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc | input | 1 | Advance pulse |
| jmp | input | 1 | Jump pulse |
| call | input | 1 | Call pulse |
| ret | input | 1 | Return pulse |
| retr | input | 1 | Return-from-interrupt pulse |
| bank0_sel | input | 1 | Clear the half-select flag |
| bank1_sel | input | 1 | Set the half-select flag |
| irq | input | 1 | Interrupt entry pulse |
| irq_vec_sel | input | 1 | Vector choice: 0 gives 003h, 1 gives 007h |
| target | input | 11 | Destination offset for jump and call |
| pc | output | 12 | Current fetch address (registered) |
| isr_active | output | 1 | High while an interrupt handler runs |

## Verification
Every result of this block appears one clock after the edge that samples the pulse: pc, isr_active, the half-select flag and the stack pointer all move on that edge, and nothing is delayed further. The bench drives pulses on the falling edge and updates its reference model on the rising edge from the same inputs. It then compares pc and isr_active on the following falling edge, so each comparison sees exactly one edge's worth of change. Effects of the flag and the stack that cannot be seen directly are brought out through a later jump or return. Those results are also checked against hand-computed addresses.

// File: rtl/bank_pc_pkg.sv
// Shared definitions for the two-bank program counter.
// Assumes a program space of two equal halves selected by the top PC bit.
package bank_pc_pkg;
    localparam int PC_WIDTH    = 12;
    localparam int STACK_SLOTS = 8;

    // One operation acts per cycle; the decoder picks it by priority.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_STEP,
        OP_JUMP,
        OP_CALL,
        OP_RET,
        OP_RETR,
        OP_IRQ
    } pc_op_e;
endpackage

// File: rtl/pc_op_decode.sv
// Picks the single operation that acts this cycle from the raw pulses.
// Assumes pulses are one cycle wide. An interrupt is accepted only outside a handler.
module pc_op_decode
    import bank_pc_pkg::*;
(
    input  logic   step_i,
    input  logic   jump_i,
    input  logic   call_i,
    input  logic   ret_i,
    input  logic   retr_i,
    input  logic   irq_i,
    input  logic   in_isr_i,
    output pc_op_e op_o
);
    // Fixed priority chain: interrupt, call, jump, retr, ret, step.
    always_comb begin
        if (irq_i && !in_isr_i) op_o = OP_IRQ;
        else if (call_i)        op_o = OP_CALL;
        else if (jump_i)        op_o = OP_JUMP;
        else if (retr_i)        op_o = OP_RETR;
        else if (ret_i)         op_o = OP_RET;
        else if (step_i)        op_o = OP_STEP;
        else                    op_o = OP_IDLE;
    end
endmodule

// File: rtl/pc_bank_latch.sv
// Deferred half-select flag. It is read only when a jump or call loads the PC.
// Assumes set wins over clear when both pulse together.
module pc_bank_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic bank_o
);
    // Holds the selected half until the next select pulse or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     bank_o <= 1'b0;
        else if (set_i) bank_o <= 1'b1;
        else if (clr_i) bank_o <= 1'b0;
    end

    p_bank_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> bank_o);
    p_bank_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !bank_o);
    p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(bank_o));
endmodule

// File: rtl/pc_ret_stack.sv
// Circular return-address stack. A push writes the slot at the pointer and
// advances it. A pop steps the pointer back. The top slot is always visible.
// Assumes push and pop never pulse together. On overflow the oldest slot is overwritten.
module pc_ret_stack #(
    parameter int WIDTH = 12,
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic [WIDTH-1:0] top_o
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

    logic [WIDTH-1:0] slot_q [SLOTS];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;

    // Neighbouring pointer values with wrap at the slot count.
    always_comb begin
        ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end

    // Most recently written slot.
    assign top_o = slot_q[ptr_dec];

    // Pointer movement.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= ptr_inc;
        else if (pop_i)  ptr_q <= ptr_dec;
    end

    // Slot storage, cleared on reset so restores are always defined.
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[s] <= '0;
                else if (push_i && ptr_q == PTR_W'(s))
                    slot_q[s] <= push_data_i;
            end
        end
    endgenerate

    p_push_on_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(push_data_i));
    p_no_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
endmodule

// File: rtl/pc_next_sel.sv
// Next-state logic for the PC, the handler flag and the stack controls.
// Assumes the PC is split into a top half bit and a low offset. Counting
// touches only the offset.
module pc_next_sel
    import bank_pc_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int VEC_A = 3,
    parameter int VEC_B = 7
) (
    input  pc_op_e          op_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            bank_i,
    input  logic            in_isr_i,
    input  logic [PC_W-2:0] target_i,
    input  logic            vec_sel_i,
    input  logic [PC_W-1:0] popped_i,
    output logic [PC_W-1:0] pc_next_o,
    output logic            isr_next_o,
    output logic            push_o,
    output logic            pop_o,
    output logic [PC_W-1:0] push_data_o
);
    localparam int OFS_W = PC_W - 1;

    logic [OFS_W-1:0] ofs_inc;
    logic             load_hi;

    // Offset plus one, wrapping inside the half; load bit is zero in a handler.
    always_comb begin
        ofs_inc = pc_i[OFS_W-1:0] + 1'b1;
        load_hi = bank_i & ~in_isr_i;
    end

    // Select next PC and stack action for the chosen operation.
    always_comb begin
        pc_next_o   = pc_i;
        isr_next_o  = in_isr_i;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_data_o = pc_i;
        unique case (op_i)
            OP_STEP: pc_next_o = {pc_i[PC_W-1], ofs_inc};
            OP_JUMP: pc_next_o = {load_hi, target_i};
            OP_CALL: begin
                pc_next_o   = {load_hi, target_i};
                push_o      = 1'b1;
                push_data_o = {pc_i[PC_W-1], ofs_inc};
            end
            OP_RET: begin
                pop_o     = 1'b1;
                pc_next_o = in_isr_i ? {1'b0, popped_i[OFS_W-1:0]} : popped_i;
            end
            OP_RETR: begin
                pop_o      = 1'b1;
                pc_next_o  = popped_i;
                isr_next_o = 1'b0;
            end
            OP_IRQ: begin
                push_o      = 1'b1;
                push_data_o = pc_i;
                pc_next_o   = vec_sel_i ? PC_W'(VEC_B) : PC_W'(VEC_A);
                isr_next_o  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bank_pc_seq.sv
// Two-bank program counter: registered PC and handler flag, fed by the
// decoder, the half-select flag, the return stack and the next-state logic.
// Assumes all control inputs are single-cycle pulses from an instruction decoder.
module bank_pc_seq
    import bank_pc_pkg::*;
#(
    parameter int PC_W  = bank_pc_pkg::PC_WIDTH,
    parameter int SLOTS = bank_pc_pkg::STACK_SLOTS,
    parameter int VEC_A = 3,
    parameter int VEC_B = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            jmp,
    input  logic            call,
    input  logic            ret,
    input  logic            retr,
    input  logic            bank0_sel,
    input  logic            bank1_sel,
    input  logic            irq,
    input  logic            irq_vec_sel,
    input  logic [PC_W-2:0] target,
    output logic [PC_W-1:0] pc,
    output logic            isr_active
);
    localparam int OFS_W = PC_W - 1;

    pc_op_e          op;
    logic            bank;
    logic [PC_W-1:0] pc_next;
    logic            isr_next;
    logic            push;
    logic            pop;
    logic [PC_W-1:0] push_data;
    logic [PC_W-1:0] popped;

    pc_op_decode u_dec (
        .step_i   (inc),
        .jump_i   (jmp),
        .call_i   (call),
        .ret_i    (ret),
        .retr_i   (retr),
        .irq_i    (irq),
        .in_isr_i (isr_active),
        .op_o     (op)
    );

    pc_bank_latch u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (bank1_sel),
        .clr_i  (bank0_sel),
        .bank_o (bank)
    );

    pc_ret_stack #(.WIDTH(PC_W), .SLOTS(SLOTS)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_data),
        .top_o       (popped)
    );

    pc_next_sel #(.PC_W(PC_W), .VEC_A(VEC_A), .VEC_B(VEC_B)) u_next (
        .op_i        (op),
        .pc_i        (pc),
        .bank_i      (bank),
        .in_isr_i    (isr_active),
        .target_i    (target),
        .vec_sel_i   (irq_vec_sel),
        .popped_i    (popped),
        .pc_next_o   (pc_next),
        .isr_next_o  (isr_next),
        .push_o      (push),
        .pop_o       (pop),
        .push_data_o (push_data)
    );

    // Architectural PC and handler flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc         <= '0;
            isr_active <= 1'b0;
        end else begin
            pc         <= pc_next;
            isr_active <= isr_next;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !isr_active));
    p_step_in_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP) |=> (pc[PC_W-1] == $past(pc[PC_W-1]) &&
                             pc[OFS_W-1:0] == $past(pc[OFS_W-1:0]) + 1'b1));
    p_select_keeps_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank0_sel || bank1_sel) && op == OP_IDLE) |=> $stable(pc));
    p_jump_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JUMP && !isr_active) |=> pc == {$past(bank), $past(target)});
    p_vector_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IRQ) |=> (isr_active && pc[PC_W-1:3] == '0 && pc[1:0] == 2'b11));
    p_handler_low_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        isr_active |-> !pc[PC_W-1]);
    p_retr_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RETR) |=> !isr_active);
    p_nested_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_active && irq && !call && !jmp && !retr && !ret && !inc) |=> $stable(pc));
endmodule

// File: tb/bank_pc_seq_test.sv
// Bench for bank_pc_seq: a behavioural reference model is compared every
// cycle, plus hand-computed address checks for each requirement.
module bank_pc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        inc, jmp, call, ret, retr, bank0_sel, bank1_sel, irq, irq_vec_sel;
    logic [10:0] target;
    logic [11:0] pc;
    logic        isr_active;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state.
    int m_pc, m_bank, m_isr, m_sp;
    int m_stk [8];

    always #10 clk = ~clk;

    bank_pc_seq uut (
        .clk(clk), .rst_n(rst_n), .inc(inc), .jmp(jmp), .call(call), .ret(ret),
        .retr(retr), .bank0_sel(bank0_sel), .bank1_sel(bank1_sel), .irq(irq),
        .irq_vec_sel(irq_vec_sel), .target(target), .pc(pc), .isr_active(isr_active)
    );

    task automatic model_update();
        int nb;
        if (!rst_n) begin
            m_pc = 0; m_bank = 0; m_isr = 0; m_sp = 0;
            for (int i = 0; i < 8; i++) m_stk[i] = 0;
            return;
        end
        nb = bank1_sel ? 1 : (bank0_sel ? 0 : m_bank);
        if (irq && m_isr == 0) begin
            m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8;
            m_pc = irq_vec_sel ? 7 : 3; m_isr = 1;
        end else if (call || jmp) begin
            if (call) begin
                m_stk[m_sp] = (m_pc & 'h800) | ((m_pc + 1) & 'h7FF);
                m_sp = (m_sp + 1) % 8;
            end
            m_pc = ((m_isr == 0 && m_bank == 1) ? 'h800 : 0) | int'(target);
        end else if (retr) begin
            m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; m_isr = 0;
        end else if (ret) begin
            m_sp = (m_sp + 7) % 8;
            m_pc = m_isr ? (m_stk[m_sp] & 'h7FF) : m_stk[m_sp];
        end else if (inc) begin
            m_pc = (m_pc & 'h800) | ((m_pc + 1) & 'h7FF);
        end
        m_bank = nb;
    endtask

    // One clock: model follows the rising edge, outputs compared at the falling edge.
    task automatic tick(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        total++;
        if (pc !== 12'(m_pc) || isr_active !== 1'(m_isr)) begin
            bad++;
            $display("FAIL %s model compare: pc=%h isr=%b expected pc=%h isr=%0d",
                     tag, pc, isr_active, 12'(m_pc), m_isr);
        end
        inc = 0; jmp = 0; call = 0; ret = 0; retr = 0;
        bank0_sel = 0; bank1_sel = 0; irq = 0; irq_vec_sel = 0;
    endtask

    task automatic chk(input string tag, input logic [11:0] exp_pc, input logic exp_isr);
        total++;
        if (pc !== exp_pc || isr_active !== exp_isr) begin
            bad++;
            $display("FAIL %s: pc=%h isr=%b expected pc=%h isr=%b",
                     tag, pc, isr_active, exp_pc, exp_isr);
        end
    endtask

    task automatic do_jmp(input string tag, input logic [10:0] t);
        jmp = 1; target = t; tick(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; inc = 0; jmp = 0; call = 0; ret = 0; retr = 0;
        bank0_sel = 0; bank1_sel = 0; irq = 0; irq_vec_sel = 0; target = '0;
        @(negedge clk);
        tick("R1"); tick("R1");
        rst_n = 1;
        chk("R1 reset state", 12'h000, 1'b0);

        // R2: advance and wrap inside lower half
        for (int i = 0; i < 5; i++) begin inc = 1; tick("R2"); end
        chk("R2 five advances", 12'h005, 1'b0);
        do_jmp("R4", 11'h7FE);
        inc = 1; tick("R2"); inc = 1; tick("R2");
        chk("R2 wrap lower half", 12'h000, 1'b0);

        // R3: select does not move pc; R4: jump takes the flag
        bank1_sel = 1; tick("R3");
        chk("R3 select keeps pc", 12'h000, 1'b0);
        do_jmp("R4", 11'h123);
        chk("R4 jump upper half", 12'h923, 1'b0);
        do_jmp("R4", 11'h7FF);
        inc = 1; tick("R2");
        chk("R2 wrap upper half", 12'h800, 1'b0);

        // R5: call saves full address, return keeps the flag
        call = 1; target = 11'h050; tick("R5");
        chk("R5 call target", 12'h850, 1'b0);
        bank0_sel = 1; tick("R3");
        ret = 1; tick("R5");
        chk("R5 return restores bit 11", 12'h801, 1'b0);
        do_jmp("R5", 11'h010);
        chk("R5 return left flag cleared", 12'h010, 1'b0);

        // R6..R9: interrupt handler behaviour
        bank1_sel = 1; tick("R3");
        irq = 1; irq_vec_sel = 0; tick("R6");
        chk("R6 vector 3", 12'h003, 1'b1);
        inc = 1; tick("R7");
        do_jmp("R7", 11'h200);
        chk("R7 jump in handler low half", 12'h200, 1'b1);
        call = 1; target = 11'h300; tick("R7");
        chk("R7 call in handler low half", 12'h300, 1'b1);
        ret = 1; tick("R7");
        chk("R7 return in handler", 12'h201, 1'b1);
        irq = 1; irq_vec_sel = 1; tick("R9");
        chk("R9 nested interrupt ignored", 12'h201, 1'b1);
        bank0_sel = 1; tick("R7");
        retr = 1; tick("R8");
        chk("R8 return from interrupt", 12'h010, 1'b0);
        do_jmp("R7", 11'h055);
        chk("R7 flag updated inside handler", 12'h055, 1'b0);
        irq = 1; irq_vec_sel = 1; tick("R6");
        chk("R6 vector 7", 12'h007, 1'b1);
        retr = 1; tick("R8");
        chk("R8 resume", 12'h055, 1'b0);

        // R3: both selects, set wins
        bank0_sel = 1; bank1_sel = 1; tick("R3");
        do_jmp("R3", 11'h0AA);
        chk("R3 set wins", 12'h8AA, 1'b0);

        // R11: priority
        call = 1; jmp = 1; inc = 1; target = 11'h120; tick("R11");
        chk("R11 call over jump and advance", 12'h920, 1'b0);
        ret = 1; inc = 1; tick("R11");
        chk("R11 return over advance", 12'h8AB, 1'b0);
        irq = 1; call = 1; jmp = 1; target = 11'h456; tick("R11");
        chk("R11 interrupt first", 12'h003, 1'b1);
        retr = 1; tick("R11");
        chk("R11 interrupt saved pc", 12'h8AB, 1'b0);

        // R10: overflow of the eight-slot stack
        bank0_sel = 1; tick("R10");
        for (int i = 0; i < 9; i++) begin
            do_jmp("R10", 11'(12'h100 + i * 16));
            call = 1; target = 11'h400; tick("R10");
        end
        ret = 1; tick("R10");
        chk("R10 newest first", 12'h181, 1'b0);
        for (int i = 0; i < 7; i++) begin ret = 1; tick("R10"); end
        chk("R10 eighth restore", 12'h111, 1'b0);
        ret = 1; tick("R10");
        chk("R10 ninth restore wraps", 12'h181, 1'b0);

        // R1: reset mid-run clears pc, handler flag and half flag
        bank1_sel = 1; tick("R1");
        irq = 1; tick("R1");
        rst_n = 0; tick("R1");
        chk("R1 mid-run reset", 12'h000, 1'b0);
        rst_n = 1;
        do_jmp("R1", 11'h044);
        chk("R1 flag cleared by reset", 12'h044, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule